// File: doc/BRIEF.md
# Multiplexed Readout Channel Scanner

The scanner walks a readout word one time-slot at a time and, for each slot, chooses which of eight sources supplies the character codes. The sources are the two channels of each of four plug-in slots. Each source presents a 4-bit column code and a 4-bit row code. The scanner takes the codes of the source named by its channel address and turns each code into a one-of-ten line select. A character drawer downstream uses those lines to pick a glyph from its matrix.

A step strobe moves the scanner through the ten time-slots of a word. After the last slot it starts a new word, pulses a word trigger and moves on to the next channel. When a slot's column code holds nothing, the display-enable output stays low and no line is selected, so no character is drawn for that slot. A disconnect input replaces the chosen source with an external pair of codes. The slot and channel counters keep running while it is asserted.

Top module: `readout_scanner`

## Requirements
- R1: While the synchronous active-high reset is asserted at a clock edge, the scanner goes to channel 0 and slot 1 with the word trigger low.
- R2: At each clock edge where step is high, the slot number increases by one. Slot and channel hold at every edge where step is low.
- R3: A step taken at slot 10 returns the slot to 1 and moves the channel up by one, from 7 back to 0. The word trigger is high for exactly the one clock that follows that edge.
- R4: The word trigger is low after every edge that did not wrap the slot.
- R5: With disconnect low, the codes used are those of source number `chan`. Source i occupies bits [4i+3:4i] of the column bus and of the row bus. Plug-in slot p, channel c is source 2p+c.
- R6: A column code k from 1 to 10 raises display-enable and sets only bit k-1 of the column select.
- R7: A column code of 0 or 11 to 15 marks an empty slot. Display-enable is then low and both selects are all zero, whatever the row code is.
- R8: When the column code is valid, a row code k from 1 to 10 sets only bit k-1 of the row select. A row code of 0 or 11 to 15 leaves the row select at zero and display-enable high.
- R9: With disconnect high, the external column and row codes replace the codes of the chosen source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| step | input | 1 | Advance to next time-slot |
| src_col | input | 32 | Column codes of eight sources, 4 bits each |
| src_row | input | 32 | Row codes of eight sources, 4 bits each |
| disc | input | 1 | Disconnect: use the external codes instead |
| ext_col | input | 4 | External column code |
| ext_row | input | 4 | External row code |
| col_sel | output | 10 | One-hot column line select |
| row_sel | output | 10 | One-hot row line select |
| disp_en | output | 1 | Current slot holds a character to draw |
| word_trig | output | 1 | One-clock pulse at the start of each word |
| chan | output | 3 | Current channel address |
| slot | output | 4 | Current time-slot number, 1 to 10 |

## Verification
The hardest case to reach from the ports is the channel address wrapping from 7 back to 0. It only happens after eighty steps, and only then is the modulo-eight behaviour and its word trigger visible. The bench steps through every word and checks slot, channel and trigger at each boundary. It also repeats the code vectors at a channel other than zero. The other seven source lanes are filled with distinct codes, so a wrong lane would show up at the outputs.

// File: rtl/readout_scanner.sv
module readout_scanner #(
  parameter int NSRC  = 8,
  parameter int NSLOT = 10,
  parameter int CW    = 4,
  parameter int NLINE = 10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        step,
  input  logic [NSRC*CW-1:0]          src_col,
  input  logic [NSRC*CW-1:0]          src_row,
  input  logic                        disc,
  input  logic [CW-1:0]               ext_col,
  input  logic [CW-1:0]               ext_row,
  output logic [NLINE-1:0]            col_sel,
  output logic [NLINE-1:0]            row_sel,
  output logic                        disp_en,
  output logic                        word_trig,
  output logic [$clog2(NSRC)-1:0]     chan,
  output logic [$clog2(NSLOT+1)-1:0]  slot
);
  localparam int AW = $clog2(NSRC);
  localparam int SW = $clog2(NSLOT + 1);

  logic [CW-1:0]    cur_col, cur_row, pick_col, pick_row;
  logic [NLINE-1:0] col_hit, row_hit;
  logic             last_slot;

  assign last_slot = (slot == SW'(NSLOT));

  always_ff @(posedge clk) begin
    if (rst) begin
      chan      <= '0;
      slot      <= SW'(1);
      word_trig <= 1'b0;
    end else begin
      word_trig <= 1'b0;
      if (step) begin
        if (last_slot) begin
          slot      <= SW'(1);
          chan      <= (chan == AW'(NSRC - 1)) ? '0 : chan + 1'b1;
          word_trig <= 1'b1;
        end else begin
          slot <= slot + 1'b1;
        end
      end
    end
  end

  assign cur_col  = src_col[chan*CW +: CW];
  assign cur_row  = src_row[chan*CW +: CW];
  assign pick_col = disc ? ext_col : cur_col;
  assign pick_row = disc ? ext_row : cur_row;

  for (genvar k = 0; k < NLINE; k++) begin : g_line
    assign col_hit[k] = (pick_col == CW'(k + 1));
    assign row_hit[k] = (pick_row == CW'(k + 1));
  end

  assign disp_en = |col_hit;
  assign col_sel = disp_en ? col_hit : '0;
  assign row_sel = disp_en ? row_hit : '0;
endmodule

// File: rtl/readout_scanner_checks.sv
module readout_scanner_checks #(
  parameter int NSRC  = 8,
  parameter int NSLOT = 10,
  parameter int NLINE = 10
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        step,
  input logic [$clog2(NSRC)-1:0]     chan,
  input logic [$clog2(NSLOT+1)-1:0]  slot,
  input logic                        word_trig,
  input logic                        disp_en,
  input logic [NLINE-1:0]            col_sel,
  input logic [NLINE-1:0]            row_sel
);
  localparam int AW = $clog2(NSRC);
  localparam int SW = $clog2(NSLOT + 1);

  a_r1_reset_state: assert property (@(posedge clk) rst |=> chan == '0 && slot == SW'(1) && !word_trig);
  a_r2_hold: assert property (@(posedge clk) disable iff (rst) !step |=> $stable(slot) && $stable(chan));
  a_r2_advance: assert property (@(posedge clk) disable iff (rst)
    step && slot != SW'(NSLOT) |=> slot == $past(slot) + 1'b1 && $stable(chan));
  a_r3_wrap: assert property (@(posedge clk) disable iff (rst)
    step && slot == SW'(NSLOT) |=> slot == SW'(1) && word_trig &&
      chan == (($past(chan) == AW'(NSRC - 1)) ? '0 : $past(chan) + 1'b1));
  a_r4_trig_single: assert property (@(posedge clk) disable iff (rst) word_trig |=> !word_trig);
  a_r6_onehot_col: assert property (@(posedge clk) disable iff (rst) disp_en |-> $countones(col_sel) == 1);
  a_r7_blank: assert property (@(posedge clk) disable iff (rst) !disp_en |-> col_sel == '0 && row_sel == '0);
  a_r8_onehot_row: assert property (@(posedge clk) disable iff (rst) $onehot0(row_sel));
endmodule

bind readout_scanner readout_scanner_checks #(.NSRC(NSRC), .NSLOT(NSLOT), .NLINE(NLINE)) u_chk (.*);

// File: tb/readout_scanner_test.sv
`timescale 1ns/1ps
module readout_scanner_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [31:0] src_col = '0, src_row = '0;
  logic        disc = 1'b0;
  logic [3:0]  ext_col = '0, ext_row = '0;
  logic [9:0]  col_sel, row_sel;
  logic        disp_en, word_trig;
  logic [2:0]  chan;
  logic [3:0]  slot;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  readout_scanner uut (.*);

  // vector: {column code, row code, disconnect}
  localparam logic [8:0] VEC [12] = '{
    {4'd1, 4'd1, 1'b0}, {4'd10, 4'd10, 1'b0}, {4'd5, 4'd3, 1'b0}, {4'd0, 4'd4, 1'b0},
    {4'd11, 4'd2, 1'b0}, {4'd15, 4'd15, 1'b0}, {4'd7, 4'd0, 1'b0}, {4'd3, 4'd12, 1'b0},
    {4'd2, 4'd9, 1'b1}, {4'd0, 4'd6, 1'b1}, {4'd10, 4'd1, 1'b1}, {4'd8, 4'd14, 1'b1}
  };

  function automatic logic [9:0] line(input logic [3:0] code);
    return (code >= 1 && code <= 10) ? (10'd1 << (code - 1)) : 10'd0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_step();
    @(negedge clk) step = 1'b1;
    @(negedge clk) step = 1'b0;
  endtask

  task automatic run_vec(input int idx);
    logic [3:0] c, r;
    logic d;
    logic [9:0] ec;
    {c, r, d} = VEC[idx];
    @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      src_col[i*4 +: 4] = 4'(i + 1);
      src_row[i*4 +: 4] = 4'(8 - i);
    end
    disc = d;
    if (d) begin
      ext_col = c; ext_row = r;
      src_col[chan*4 +: 4] = 4'd6; src_row[chan*4 +: 4] = 4'd6;
    end else begin
      ext_col = 4'd9; ext_row = 4'd9;
      src_col[chan*4 +: 4] = c; src_row[chan*4 +: 4] = r;
    end
    #1;
    ec = line(c);
    chk(d ? "R9 col" : "R5/R6 col", col_sel, ec);
    chk(ec == 0 ? "R7 en" : "R6 en", disp_en, ec != 0);
    chk(ec == 0 ? "R7 row" : "R8 row", row_sel, ec != 0 ? line(r) : 10'd0);
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    chk("R1 chan", chan, 0);
    chk("R1 slot", slot, 1);
    chk("R1 trig", word_trig, 0);

    for (int v = 0; v < 12; v++) run_vec(v);

    repeat (4) @(negedge clk);
    chk("R2 hold slot", slot, 1);
    chk("R2 hold chan", chan, 0);

    for (int s = 2; s <= 10; s++) begin
      do_step();
      chk("R2 advance", slot, s);
      chk("R4 no trig", word_trig, 0);
    end

    for (int w = 1; w <= 8; w++) begin
      @(negedge clk) step = 1'b1;
      @(posedge clk); #1 step = 1'b0;
      @(negedge clk);
      chk("R3 wrap slot", slot, 1);
      chk("R3 chan", chan, w % 8);
      chk("R3 trig", word_trig, 1);
      @(negedge clk);
      chk("R3 trig one clock", word_trig, 0);
      if (w == 5) begin
        for (int v = 0; v < 12; v++) run_vec(v);
      end
      if (w < 8) begin
        for (int s = 2; s <= 10; s++) do_step();
        chk("R2 reach slot 10", slot, 10);
      end
    end

    do_step();
    do_step();
    @(negedge clk) rst = 1'b1;
    @(negedge clk) rst = 1'b0;
    chk("R1 reset again slot", slot, 1);
    chk("R1 reset again chan", chan, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule